// File: doc/BRIEF.md
# Encoder Stall and Speed Checker

This block watches one stepper axis. It decodes a two-channel quadrature encoder at four counts per encoder cycle and keeps a signed position. It also counts the step strobes that the step generator issues. Each run of a fixed number of encoder edges in one direction closes a check window. At that point the block compares the steps issued in the window against the number the gear ratio predicts. A motor that has stalled or fallen behind shows up as a window whose step total is too high or too low.

Some mismatches are tolerated, up to a set count. The next mismatch after that latches a fault, and the fault drops the drive-enable output. Only an explicit clear, given while the axis is disabled, releases the fault. Both encoder channels pass through a two-flop synchroniser and a stability filter before decoding. A transition in which both channels change together is counted as an error and does not move the position.

Top module: `enc_speed_guard`

## Requirements
- R1: Each legal encoder transition changes `pos_o` by exactly one. The forward phase order of {a,b} is 00, 01, 11, 10, 00 and adds one; the reverse order subtracts one. Position tracking runs whether or not the axis is enabled.
- R2: A transition in which both channels change at once leaves `pos_o` unchanged and raises `illegal_cnt_o` by one, saturating at its maximum.
- R3: Each encoder input is synchronised by two flops. A new level reaches the decoder only after it has been seen for `DEB_CYCLES` consecutive clocks, so a pulse lasting one clock has no effect on `pos_o` or `illegal_cnt_o`.
- R4: While enabled, `check_o` pulses high for one clock after every `EDGES_PER_CHECK` (default 12) consecutive edges in the same direction.
- R5: An edge opposite to the current run's direction, arriving while a run is in progress, returns the run to zero edges and discards the steps counted in the window. It raises no check.
- R6: Step strobes (`step_i` high for a clock) are counted while enabled. At a check the window total is compared against USTEP_PER_REV/(4*ENC_CPR)*EDGES_PER_CHECK, which is 96 by default. The window is a mismatch when it differs from that value by more than `TOL` (default 4), so 92..100 pass and 91 or 101 fail.
- R7: Each mismatch raises `miss_cnt_o` by one until it reaches `MAX_MISS` (default 10). The next mismatch after that sets `fault_o`, and `miss_cnt_o` stays at `MAX_MISS`.
- R8: Once set, `fault_o` stays set through later windows, good or bad. `drive_en_o` equals `enable_i` and not `fault_o`.
- R9: `fault_clr_i` with `enable_i` low clears `fault_o` and `miss_cnt_o` on the next clock. `fault_clr_i` with `enable_i` high has no effect.
- R10: While `enable_i` is low, no check is raised, and both the edge run and the step window are held at zero.
- R11: After reset, `pos_o`, `miss_cnt_o`, `illegal_cnt_o`, `check_o` and `fault_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Axis commanded to run |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| step_i | input | 1 | Step strobe, one step per high clock |
| fault_clr_i | input | 1 | Fault clear request, honoured only while disabled |
| pos_o | output | POS_W | Signed encoder position in x4 counts |
| check_o | output | 1 | One-clock pulse at each check window close |
| miss_cnt_o | output | MISS_W | Mismatches seen since last clear |
| fault_o | output | 1 | Latched speed fault |
| drive_en_o | output | 1 | Motor drive enable |
| illegal_cnt_o | output | ERR_W | Count of illegal encoder transitions |

## Verification
An edge run counter that drifts shifts the moment `check_o` fires, or removes it, within the same window. The pulse count the bench compares after each twelve edges therefore exposes the drift within one window. A step window that keeps stale steps from a reversal, or from a disabled interval, produces a false mismatch. That mismatch shows up in `miss_cnt_o` at the next check. Errors in the tolerance bound or the fault latch appear as a wrong count, or a wrong `fault_o`/`drive_en_o` level, at the first window that crosses the boundary. The sweep of step totals across 88..104 steps onto each such boundary.

// File: rtl/enc_guard_pkg.sv
package enc_guard_pkg;

  // {a,b} -> position in the forward phase cycle 00,01,11,10
  function automatic logic [1:0] quad_phase(input logic a, input logic b);
    return {a, a ^ b};
  endfunction

endpackage

// File: rtl/enc_input_filter.sv
module enc_input_filter #(
  parameter int DEB_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int POS_W = 32,
  parameter int ERR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    a_i,
  input  logic                    b_i,
  output logic                    edge_o,
  output logic                    dir_o,
  output logic signed [POS_W-1:0] pos_o,
  output logic [ERR_W-1:0]        err_cnt_o
);
  import enc_guard_pkg::*;

  logic [1:0]              phase_q, phase_d, delta;
  logic                    edge_q, dir_q;
  logic signed [POS_W-1:0] pos_q;
  logic [ERR_W-1:0]        err_q;

  assign phase_d = quad_phase(a_i, b_i);
  assign delta   = phase_d - phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 2'b00;
      edge_q  <= 1'b0;
      dir_q   <= 1'b1;
      pos_q   <= '0;
      err_q   <= '0;
    end else begin
      phase_q <= phase_d;
      edge_q  <= 1'b0;
      unique case (delta)
        2'd1: begin
          pos_q  <= pos_q + POS_W'(1);
          edge_q <= 1'b1;
          dir_q  <= 1'b1;
        end
        2'd3: begin
          pos_q  <= pos_q - POS_W'(1);
          edge_q <= 1'b1;
          dir_q  <= 1'b0;
        end
        2'd2: if (err_q != '1) err_q <= err_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign edge_o    = edge_q;
  assign dir_o     = dir_q;
  assign pos_o     = pos_q;
  assign err_cnt_o = err_q;
endmodule

// File: rtl/speed_window.sv
module speed_window #(
  parameter int EDGES_PER_CHECK = 12,
  parameter int EXP_STEPS       = 96,
  parameter int TOL             = 4,
  parameter int MAX_MISS        = 10,
  parameter int STEP_W          = 16,
  parameter int MISS_W          = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              step_i,
  input  logic              edge_i,
  input  logic              dir_i,
  input  logic              fault_clr_i,
  output logic              check_o,
  output logic [MISS_W-1:0] miss_cnt_o,
  output logic              fault_o
);
  localparam int RW  = $clog2(EDGES_PER_CHECK + 1);
  localparam int SW2 = STEP_W + 2;

  logic [RW-1:0]         run_q;
  logic                  run_dir_q;
  logic [STEP_W-1:0]     step_q, step_sum;
  logic                  check_q, fault_q;
  logic [MISS_W-1:0]     miss_q;
  logic                  step_now, mism, clear_ok;
  logic signed [SW2-1:0] dev;

  assign step_now = enable_i & step_i;
  assign step_sum = (step_q == '1) ? step_q : step_q + STEP_W'(step_now);
  assign dev      = $signed({2'b00, step_sum}) - $signed(SW2'(EXP_STEPS));
  assign mism     = (dev > $signed(SW2'(TOL))) || (dev < -$signed(SW2'(TOL)));
  assign clear_ok = fault_clr_i & ~enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      run_dir_q <= 1'b1;
      step_q    <= '0;
      check_q   <= 1'b0;
      miss_q    <= '0;
      fault_q   <= 1'b0;
    end else begin
      check_q <= 1'b0;
      if (clear_ok) begin
        fault_q <= 1'b0;
        miss_q  <= '0;
      end
      if (!enable_i) begin
        run_q  <= '0;
        step_q <= '0;
      end else begin
        step_q <= step_sum;
        if (edge_i) begin
          if (run_q != '0 && dir_i != run_dir_q) begin
            // reversal: restart both run and window
            run_q  <= '0;
            step_q <= STEP_W'(step_now);
          end else if (run_q == RW'(EDGES_PER_CHECK - 1)) begin
            check_q <= 1'b1;
            run_q   <= '0;
            step_q  <= '0;
            if (mism) begin
              if (miss_q == MISS_W'(MAX_MISS)) fault_q <= 1'b1;
              else                              miss_q  <= miss_q + 1'b1;
            end
          end else begin
            run_q     <= run_q + 1'b1;
            run_dir_q <= dir_i;
          end
        end
      end
    end
  end

  assign check_o    = check_q;
  assign miss_cnt_o = miss_q;
  assign fault_o    = fault_q;
endmodule

// File: rtl/enc_speed_guard.sv
module enc_speed_guard #(
  parameter int ENC_CPR         = 400,
  parameter int USTEP_PER_REV   = 12800,
  parameter int EDGES_PER_CHECK = 12,
  parameter int TOL             = 4,
  parameter int MAX_MISS        = 10,
  parameter int DEB_CYCLES      = 2,
  parameter int POS_W           = 32,
  parameter int STEP_W          = 16,
  parameter int ERR_W           = 8,
  parameter int MISS_W          = $clog2(MAX_MISS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    enc_a_i,
  input  logic                    enc_b_i,
  input  logic                    step_i,
  input  logic                    fault_clr_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic                    check_o,
  output logic [MISS_W-1:0]       miss_cnt_o,
  output logic                    fault_o,
  output logic                    drive_en_o,
  output logic [ERR_W-1:0]        illegal_cnt_o
);
  localparam int STEPS_PER_EDGE = USTEP_PER_REV / (4 * ENC_CPR);
  localparam int EXP_STEPS      = STEPS_PER_EDGE * EDGES_PER_CHECK;

  logic [1:0] raw_ch, filt_ch;
  logic       enc_edge, enc_dir;

  assign raw_ch = {enc_a_i, enc_b_i};

  for (genvar g = 0; g < 2; g++) begin : g_chan
    enc_input_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_ch[g]),
      .filt_o (filt_ch[g])
    );
  end

  quad_decoder #(.POS_W(POS_W), .ERR_W(ERR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (filt_ch[1]),
    .b_i       (filt_ch[0]),
    .edge_o    (enc_edge),
    .dir_o     (enc_dir),
    .pos_o     (pos_o),
    .err_cnt_o (illegal_cnt_o)
  );

  speed_window #(
    .EDGES_PER_CHECK(EDGES_PER_CHECK),
    .EXP_STEPS      (EXP_STEPS),
    .TOL            (TOL),
    .MAX_MISS       (MAX_MISS),
    .STEP_W         (STEP_W),
    .MISS_W         (MISS_W)
  ) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .step_i      (step_i),
    .edge_i      (enc_edge),
    .dir_i       (enc_dir),
    .fault_clr_i (fault_clr_i),
    .check_o     (check_o),
    .miss_cnt_o  (miss_cnt_o),
    .fault_o     (fault_o)
  );

  assign drive_en_o = enable_i & ~fault_o;
endmodule

// File: rtl/enc_speed_guard_chk.sv
module enc_speed_guard_chk #(
  parameter int POS_W    = 32,
  parameter int MISS_W   = 4,
  parameter int ERR_W    = 8,
  parameter int MAX_MISS = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    enable_i,
  input logic                    fault_clr_i,
  input logic signed [POS_W-1:0] pos_o,
  input logic                    check_o,
  input logic [MISS_W-1:0]       miss_cnt_o,
  input logic                    fault_o,
  input logic                    drive_en_o,
  input logic [ERR_W-1:0]        illegal_cnt_o
);
  p_pos_unit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_o) |-> ((pos_o - $past(pos_o)) == POS_W'(1)) ||
                        (($past(pos_o) - pos_o) == POS_W'(1)));

  p_illegal_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(illegal_cnt_o) |-> $stable(pos_o));

  p_check_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o |=> !check_o);

  p_miss_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o <= MISS_W'(MAX_MISS));

  p_fault_at_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> miss_cnt_o == MISS_W'(MAX_MISS));

  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !(fault_clr_i && !enable_i)) |=> fault_o);

  p_drive_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !drive_en_o);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_clr_i && !enable_i) |=> (!fault_o && miss_cnt_o == '0));

  p_check_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o |-> $past(enable_i));
endmodule

bind enc_speed_guard enc_speed_guard_chk #(
  .POS_W(POS_W), .MISS_W(MISS_W), .ERR_W(ERR_W), .MAX_MISS(MAX_MISS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .fault_clr_i  (fault_clr_i),
  .pos_o        (pos_o),
  .check_o      (check_o),
  .miss_cnt_o   (miss_cnt_o),
  .fault_o      (fault_o),
  .drive_en_o   (drive_en_o),
  .illegal_cnt_o(illegal_cnt_o)
);

// File: tb/enc_speed_guard_test.sv
module enc_speed_guard_test;
  localparam int POS_W = 32, ERR_W = 8, MAX_MISS = 10, MISS_W = 4;
  localparam int EXP = 96, TOL = 4, EDGES = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, enc_a = 1'b0, enc_b = 1'b0, step = 1'b0, fclr = 1'b0;
  logic signed [POS_W-1:0] pos;
  logic check, fault, drive_en;
  logic [MISS_W-1:0] miss;
  logic [ERR_W-1:0] ill;

  enc_speed_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .enc_a_i(enc_a),
    .enc_b_i(enc_b), .step_i(step), .fault_clr_i(fclr), .pos_o(pos),
    .check_o(check), .miss_cnt_o(miss), .fault_o(fault),
    .drive_en_o(drive_en), .illegal_cnt_o(ill)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, chk_seen = 0;
  int g = 0, pos_m = 0, miss_m = 0, chk_m = 0, ill_m = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && check) chk_seen++;

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ab_of(int ph);
    case (ph & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic set_phase(int ph);
    @(negedge clk);
    {enc_a, enc_b} = ab_of(ph);
    repeat (8) @(negedge clk);
  endtask

  task automatic edge_fwd(int n);
    for (int i = 0; i < n; i++) begin g = (g + 1) % 4; pos_m++; set_phase(g); end
  endtask

  task automatic edge_rev(int n);
    for (int i = 0; i < n; i++) begin g = (g + 3) % 4; pos_m--; set_phase(g); end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) step = 1'b1;
      @(negedge clk) step = 1'b0;
    end
  endtask

  // one full window: n steps then a full forward run while enabled
  task automatic window(int n);
    steps(n);
    edge_fwd(EDGES);
    chk_m++;
    if (n - EXP > TOL || EXP - n > TOL) begin
      if (miss_m < MAX_MISS) miss_m++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    cmp("R11 pos", int'(pos), 0);
    cmp("R11 miss", int'(miss), 0);
    cmp("R11 illegal", int'(ill), 0);
    cmp("R11 fault", int'(fault), 0);
    cmp("R11 check", int'(check), 0);
    cmp("R8 drive off when disabled", int'(drive_en), 0);

    enable = 1'b1;
    @(negedge clk);
    cmp("R8 drive on", int'(drive_en), 1);

    // R6 sweep of step totals across the tolerance boundaries
    for (int n = EXP - 8; n <= EXP + 8; n++) begin
      window(n);
      cmp($sformatf("R4 checks after %0d steps", n), chk_seen, chk_m);
      cmp($sformatf("R6 miss after %0d steps", n), int'(miss), miss_m);
      cmp("R1 position", int'(pos), pos_m);
    end
    cmp("R7 no fault below cap", int'(fault), 0);

    // R5 reversal restarts the run and the window
    steps(48);
    edge_fwd(6);
    edge_rev(1);
    cmp("R5 no check on reversal", chk_seen, chk_m);
    steps(EXP);
    edge_rev(EDGES - 1);
    cmp("R5 run restarted", chk_seen, chk_m);
    edge_rev(1);
    chk_m++;
    cmp("R5 check after reverse run", chk_seen, chk_m);
    cmp("R5 window restarted", int'(miss), miss_m);
    cmp("R1 reverse position", int'(pos), pos_m);

    // R10 disabled: position tracks, no checks, window held at zero
    enable = 1'b0;
    steps(EXP);
    edge_fwd(EDGES);
    cmp("R10 no check disabled", chk_seen, chk_m);
    cmp("R10 position tracks", int'(pos), pos_m);
    enable = 1'b1;
    window(EXP);
    cmp("R10 check after enable", chk_seen, chk_m);
    cmp("R10 window held at zero", int'(miss), miss_m);

    // R7 reach the cap, then latch
    window(0);
    window(0);
    cmp("R7 miss at cap", int'(miss), MAX_MISS);
    cmp("R7 no fault at cap", int'(fault), 0);
    window(0);
    cmp("R7 fault latched", int'(fault), 1);
    cmp("R7 miss held", int'(miss), MAX_MISS);
    cmp("R8 drive removed", int'(drive_en), 0);
    window(EXP);
    cmp("R8 fault sticky", int'(fault), 1);

    // R9 clear only while disabled
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    @(negedge clk);
    cmp("R9 clear ignored enabled", int'(fault), 1);
    cmp("R9 miss kept enabled", int'(miss), MAX_MISS);
    enable = 1'b0;
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    cmp("R9 fault cleared", int'(fault), 0);
    cmp("R9 miss cleared", int'(miss), 0);
    miss_m = 0;
    enable = 1'b1;
    @(negedge clk);
    cmp("R8 drive restored", int'(drive_en), 1);

    // R2 illegal jump
    g = (g + 2) % 4;
    set_phase(g);
    ill_m++;
    cmp("R2 illegal count", int'(ill), ill_m);
    cmp("R2 position held", int'(pos), pos_m);
    edge_fwd(1);
    cmp("R1 resumes after illegal", int'(pos), pos_m);

    // R3 one-clock glitch on each channel
    @(negedge clk) enc_a = ~enc_a;
    @(negedge clk) enc_a = ~enc_a;
    repeat (8) @(negedge clk);
    @(negedge clk) enc_b = ~enc_b;
    @(negedge clk) enc_b = ~enc_b;
    repeat (8) @(negedge clk);
    cmp("R3 glitch position", int'(pos), pos_m);
    cmp("R3 glitch illegal", int'(ill), ill_m);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule